// File: doc/BRIEF.md
# ASCII Time-of-Day Counter with Alarm and Snooze

This block keeps the time of day in 24-hour form as six ASCII-coded digit bytes (hours, minutes, seconds; each digit n held as 0x30+n). A slow 1 Hz tick input advances the time by one second on each of its low-to-high transitions. The digits roll over one at a time, with carries from seconds into minutes, minutes into hours, and 23:59:59 wrapping to 00:00:00.

The block also holds an alarm time, a separate snooze target and an enable flag. The alarm output is raised when the enable flag is set and the time, just after a step, equals the snooze target. It then stays raised until a dismiss or a snooze request arrives. Writing a new alarm time also sets the snooze target to that time. A snooze request pushes the target forward by a parameterised number of minutes (three by default, which is 180 seconds), wrapping across midnight. A tone output carries a square wave derived from the system clock, gated by the alarm output.

A load port writes either the time or the alarm time from one 48-bit digit word. A word with any digit out of range is dropped.

Top module: `clock_alarm_core`

## Requirements
- R1: In any cycle where `rst` is high, `time_out`, `alarm_time` and `snooze_time` become 0x303030303030 (00:00:00), and `alarm_en`, `alarm_active` and `tone` become 0.
- R2: The time advances by exactly one second for each low-to-high change of `tick_1hz`. `time_out` shows the new value after the first clock edge at which the tick is seen high. Holding the tick high gives no further steps.
- R3: The seconds ones and minutes ones digits wrap from '9' to '0' and carry into the next digit. The seconds tens and minutes tens digits wrap from '5' to '0' and carry into the next digit (for example, 09:59:59 steps to 10:00:00).
- R4: The hours ones digit wraps from '9' to '0' with a carry while the hours tens digit is below '2'. When the hours tens digit is '2', 23:59:59 steps to 00:00:00 (for example, 19:59:59 steps to 20:00:00).
- R5: A `load_time` pulse with a valid word replaces the time at the next clock edge, and it takes priority over a tick step in the same cycle. Word layout: bits 47:40 hours tens, 39:32 hours ones, 31:24 minutes tens, 23:16 minutes ones, 15:8 seconds tens, 7:0 seconds ones.
- R6: A load word is valid only when every byte lies in 0x30..0x39, both tens digits are at most '5', the hours tens digit is at most '2', and the hour is at most 23. A time or alarm load with an invalid word leaves all stored values unchanged.
- R7: A `load_alarm` pulse with a valid word sets both `alarm_time` and `snooze_time` to that word at the next edge.
- R8: The alarm condition is checked once per time step. `alarm_active` rises one clock after a step that makes `time_out` equal to `snooze_time`, provided `alarm_en` is 1. It then stays high across further steps. A load that makes the two values equal does not fire the alarm.
- R9: While `alarm_active` is high, a `snooze_req` clears it and advances `snooze_time` by SNOOZE_MIN minutes (default 3, which is 180 s), modulo 24 h. While `alarm_active` is low, a `snooze_req` is ignored.
- R10: `dismiss_req` clears both `alarm_active` and `alarm_en`. `toggle_en` inverts `alarm_en`. If both arrive in the same cycle, the dismiss wins.
- R11: `tone` is a 50% square wave with a period of CLK_HZ/TONE_HZ clocks while `alarm_active` is high, and it is 0 while `alarm_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | Seconds tick; each rising transition is one step |
| load_time | input | 1 | Write `load_value` into the time |
| load_alarm | input | 1 | Write `load_value` into the alarm time and the snooze target |
| load_value | input | 48 | Six ASCII digits, hours tens in the top byte |
| snooze_req | input | 1 | Postpone a ringing alarm |
| dismiss_req | input | 1 | Stop the alarm and disarm it |
| toggle_en | input | 1 | Flip the alarm enable flag |
| time_out | output | 48 | Current time, ASCII digits |
| alarm_time | output | 48 | Stored alarm time |
| snooze_time | output | 48 | Current snooze target |
| alarm_en | output | 1 | Alarm armed |
| alarm_active | output | 1 | Alarm ringing |
| tone | output | 1 | Gated square-wave tone |

## Verification
A wrong carry or rollover path shows on `time_out` at the very step that crosses the faulty boundary, one clock after the tick edge. The bench therefore walks the time across every tens and hours boundary and compares each step. A corrupted snooze target or enable flag shows only when the next matching step fires the alarm or fails to, which can be many ticks later. For that reason `snooze_time` is compared directly after every alarm load and every snooze. A fault in the tone divider shows as a wrong count of high samples within one tone period while the alarm is ringing.

// File: rtl/clk_alarm_pkg.sv
package clk_alarm_pkg;

    typedef logic [7:0] ascii_t;

    typedef struct packed {
        ascii_t h_t;
        ascii_t h_o;
        ascii_t m_t;
        ascii_t m_o;
        ascii_t s_t;
        ascii_t s_o;
    } hms_t;

    localparam ascii_t CH0 = 8'h30;
    localparam hms_t   HMS_ZERO = {6{CH0}};

    function automatic logic digit_ok(ascii_t c, ascii_t maxch);
        return (c >= CH0) && (c <= maxch);
    endfunction

    function automatic logic hms_ok(hms_t t);
        logic r;
        r = digit_ok(t.h_t, 8'h32) && digit_ok(t.h_o, 8'h39) &&
            digit_ok(t.m_t, 8'h35) && digit_ok(t.m_o, 8'h39) &&
            digit_ok(t.s_t, 8'h35) && digit_ok(t.s_o, 8'h39);
        if (t.h_t == 8'h32 && t.h_o > 8'h33)
            r = 1'b0;
        return r;
    endfunction

    // One-second step with digit-wise carries
    function automatic hms_t step_sec(hms_t t);
        hms_t r;
        r = t;
        if (t.s_o != 8'h39) begin
            r.s_o = t.s_o + 8'd1;
        end else begin
            r.s_o = CH0;
            if (t.s_t != 8'h35) begin
                r.s_t = t.s_t + 8'd1;
            end else begin
                r.s_t = CH0;
                if (t.m_o != 8'h39) begin
                    r.m_o = t.m_o + 8'd1;
                end else begin
                    r.m_o = CH0;
                    if (t.m_t != 8'h35) begin
                        r.m_t = t.m_t + 8'd1;
                    end else begin
                        r.m_t = CH0;
                        if (t.h_t == 8'h32 && t.h_o == 8'h33) begin
                            r.h_t = CH0;
                            r.h_o = CH0;
                        end else if (t.h_t != 8'h32 && t.h_o == 8'h39) begin
                            r.h_o = CH0;
                            r.h_t = t.h_t + 8'd1;
                        end else begin
                            r.h_o = t.h_o + 8'd1;
                        end
                    end
                end
            end
        end
        return r;
    endfunction

    // Forward by n minutes (n < 60), seconds untouched, wraps at 24 h
    function automatic hms_t add_minutes(hms_t t, int n);
        hms_t r;
        int   mn;
        int   hr;
        r  = t;
        mn = (int'(t.m_t) - 48) * 10 + (int'(t.m_o) - 48) + n;
        hr = (int'(t.h_t) - 48) * 10 + (int'(t.h_o) - 48);
        if (mn >= 60) begin
            mn = mn - 60;
            hr = hr + 1;
        end
        if (hr >= 24)
            hr = hr - 24;
        r.m_t = ascii_t'(48 + mn / 10);
        r.m_o = ascii_t'(48 + mn % 10);
        r.h_t = ascii_t'(48 + hr / 10);
        r.h_o = ascii_t'(48 + hr % 10);
        return r;
    endfunction

endpackage

// File: rtl/tod_counter.sv
module tod_counter
    import clk_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load_en,
    input  hms_t load_val,
    output hms_t time_q,
    output logic stepped
);

    logic tick_q;
    logic tick_rise;

    assign tick_rise = tick & ~tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q  <= HMS_ZERO;
            tick_q  <= 1'b1;
            stepped <= 1'b0;
        end else begin
            tick_q  <= tick;
            stepped <= 1'b0;
            if (load_en && hms_ok(load_val)) begin
                time_q <= load_val;
            end else if (tick_rise) begin
                time_q  <= step_sec(time_q);
                stepped <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
    import clk_alarm_pkg::*;
#(
    parameter int SNOOZE_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic stepped,
    input  hms_t time_q,
    input  logic load_en,
    input  hms_t load_val,
    input  logic snooze_req,
    input  logic dismiss_req,
    input  logic toggle_en,
    output hms_t alarm_q,
    output hms_t snooze_q,
    output logic en_q,
    output logic active_q
);

    logic do_snooze;
    logic hit;

    assign do_snooze = snooze_req & active_q;
    assign hit       = stepped & en_q & (time_q == snooze_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q  <= HMS_ZERO;
            snooze_q <= HMS_ZERO;
            en_q     <= 1'b0;
            active_q <= 1'b0;
        end else begin
            if (load_en && hms_ok(load_val)) begin
                alarm_q  <= load_val;
                snooze_q <= load_val;
            end else if (do_snooze) begin
                snooze_q <= add_minutes(snooze_q, SNOOZE_MIN);
            end

            if (dismiss_req)
                en_q <= 1'b0;
            else if (toggle_en)
                en_q <= ~en_q;

            if (dismiss_req || do_snooze)
                active_q <= 1'b0;
            else if (hit)
                active_q <= 1'b1;
        end
    end

endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
    parameter int HALF_CYC = 62500
) (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic tone
);

    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt;
    logic          sq;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (cnt == CW'(HALF_CYC - 1)) begin
            cnt <= '0;
            sq  <= ~sq;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tone = sq & gate;

endmodule

// File: rtl/clock_alarm_core.sv
module clock_alarm_core
    import clk_alarm_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int TONE_HZ    = 1000,
    parameter int SNOOZE_MIN = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_1hz,
    input  logic        load_time,
    input  logic        load_alarm,
    input  logic [47:0] load_value,
    input  logic        snooze_req,
    input  logic        dismiss_req,
    input  logic        toggle_en,
    output logic [47:0] time_out,
    output logic [47:0] alarm_time,
    output logic [47:0] snooze_time,
    output logic        alarm_en,
    output logic        alarm_active,
    output logic        tone
);

    localparam int HALF_CYC = CLK_HZ / (2 * TONE_HZ);

    hms_t ld_word;
    hms_t now_q;
    hms_t alm_q;
    hms_t snz_q;
    logic stepped;

    assign ld_word = hms_t'(load_value);

    tod_counter u_tod (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .load_en  (load_time),
        .load_val (ld_word),
        .time_q   (now_q),
        .stepped  (stepped)
    );

    alarm_ctrl #(.SNOOZE_MIN(SNOOZE_MIN)) u_alm (
        .clk         (clk),
        .rst         (rst),
        .stepped     (stepped),
        .time_q      (now_q),
        .load_en     (load_alarm),
        .load_val    (ld_word),
        .snooze_req  (snooze_req),
        .dismiss_req (dismiss_req),
        .toggle_en   (toggle_en),
        .alarm_q     (alm_q),
        .snooze_q    (snz_q),
        .en_q        (alarm_en),
        .active_q    (alarm_active)
    );

    tone_gen #(.HALF_CYC(HALF_CYC)) u_tone (
        .clk  (clk),
        .rst  (rst),
        .gate (alarm_active),
        .tone (tone)
    );

    assign time_out    = now_q;
    assign alarm_time  = alm_q;
    assign snooze_time = snz_q;

endmodule

// File: rtl/clock_alarm_chk.sv
module clock_alarm_chk
    import clk_alarm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tick_1hz,
    input logic        load_time,
    input logic        load_alarm,
    input logic [47:0] load_value,
    input logic        snooze_req,
    input logic        dismiss_req,
    input logic        toggle_en,
    input logic [47:0] time_out,
    input logic [47:0] alarm_time,
    input logic [47:0] snooze_time,
    input logic        alarm_en,
    input logic        alarm_active,
    input logic        tone
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (time_out == HMS_ZERO) && (snooze_time == HMS_ZERO) &&
                !alarm_en && !alarm_active);

    // R2
    no_spurious_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_time && !(tick_1hz && !$past(tick_1hz))) |=> $stable(time_out));

    // R6
    digits_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        hms_ok(hms_t'(time_out)) && hms_ok(hms_t'(snooze_time)));

    // R7
    alarm_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_alarm && hms_ok(hms_t'(load_value))) |=>
            (alarm_time == $past(load_value)) && (snooze_time == $past(load_value)));

    // R8
    fire_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_active) |-> alarm_en && (time_out == snooze_time));

    // R9
    snooze_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (snooze_req && alarm_active) |=> !alarm_active);

    // R10
    dismiss_chk: assert property (@(posedge clk) disable iff (rst)
        dismiss_req |=> !alarm_active && !alarm_en);

    // R11
    quiet_tone_chk: assert property (@(posedge clk) disable iff (rst)
        !alarm_active |-> !tone);

endmodule

bind clock_alarm_core clock_alarm_chk u_chk (.*);

// File: tb/sim_clock_alarm_core.sv
module sim_clock_alarm_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        load_time = 1'b0;
    logic        load_alarm = 1'b0;
    logic [47:0] load_value = '0;
    logic        snooze_req = 1'b0;
    logic        dismiss_req = 1'b0;
    logic        toggle_en = 1'b0;
    logic [47:0] time_out;
    logic [47:0] alarm_time;
    logic [47:0] snooze_time;
    logic        alarm_en;
    logic        alarm_active;
    logic        tone;

    int errors = 0;
    int checks = 0;
    int secs   = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    clock_alarm_core #(.CLK_HZ(20000), .TONE_HZ(1000), .SNOOZE_MIN(3)) u0 (.*);

    function automatic logic [47:0] to_asc(int s);
        int h;
        int m;
        int x;
        h = (s / 3600) % 24;
        m = (s / 60) % 60;
        x = s % 60;
        return {8'(48 + h / 10), 8'(48 + h % 10), 8'(48 + m / 10),
                8'(48 + m % 10), 8'(48 + x / 10), 8'(48 + x % 10)};
    endfunction

    function automatic int hms(int h, int m, int s);
        return h * 3600 + m * 60 + s;
    endfunction

    task automatic chk48(string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk);
        @(negedge clk) tick_1hz = 1'b0;
        @(negedge clk);
        secs = (secs + 1) % 86400;
    endtask

    task automatic pulse_load(bit alm, logic [47:0] v);
        @(negedge clk);
        load_value = v;
        if (alm) load_alarm = 1'b1; else load_time = 1'b1;
        @(negedge clk);
        load_alarm = 1'b0;
        load_time  = 1'b0;
    endtask

    task automatic set_time(int s);
        pulse_load(1'b0, to_asc(s));
        secs = s;
    endtask

    task automatic pulse_snooze();
        @(negedge clk) snooze_req = 1'b1;
        @(negedge clk) snooze_req = 1'b0;
    endtask

    task automatic pulse_dismiss();
        @(negedge clk) dismiss_req = 1'b1;
        @(negedge clk) dismiss_req = 1'b0;
    endtask

    task automatic pulse_toggle();
        @(negedge clk) toggle_en = 1'b1;
        @(negedge clk) toggle_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int a;
        int hi;
        logic [47:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk48("R1 time", time_out, 48'h303030303030);
        chk48("R1 alarm", alarm_time, 48'h303030303030);
        chk48("R1 snooze", snooze_time, 48'h303030303030);
        chk1("R1 en", alarm_en, 1'b0);
        chk1("R1 active", alarm_active, 1'b0);
        chk1("R1 tone", tone, 1'b0);

        // R2 stepping from reset
        for (int i = 0; i < 12; i++) begin
            do_tick();
            chk48("R2 step", time_out, to_asc(secs));
        end

        // R2 held tick gives one step only
        @(negedge clk) tick_1hz = 1'b1;
        repeat (6) @(negedge clk);
        secs = secs + 1;
        chk48("R2 held tick", time_out, to_asc(secs));
        @(negedge clk) tick_1hz = 1'b0;
        @(negedge clk);
        chk48("R2 fall no step", time_out, to_asc(secs));

        // R3 / R4 boundary walks
        set_time(hms(9, 59, 58));
        do_tick(); chk48("R3 59s", time_out, to_asc(secs));
        do_tick(); chk48("R3 carry to hours ones", time_out, 48'h313030303030);
        set_time(hms(19, 59, 59));
        do_tick(); chk48("R4 19->20", time_out, 48'h323030303030);
        set_time(hms(23, 59, 58));
        do_tick(); chk48("R4 23:59:59", time_out, to_asc(secs));
        do_tick(); chk48("R4 wrap to 00", time_out, 48'h303030303030);
        do_tick(); chk48("R4 after wrap", time_out, 48'h303030303031);
        set_time(hms(12, 9, 59));
        do_tick(); chk48("R3 min ones", time_out, to_asc(secs));

        // R5 random valid loads and stepping
        for (int i = 0; i < 20; i++) begin
            set_time(int'($urandom % 86400));
            chk48("R5 load", time_out, to_asc(secs));
            do_tick();
            chk48("R3 random step", time_out, to_asc(secs));
        end

        // R5 load beats tick in same cycle
        @(negedge clk);
        tick_1hz = 1'b1;
        load_time = 1'b1;
        load_value = to_asc(hms(5, 5, 5));
        @(negedge clk);
        load_time = 1'b0;
        @(negedge clk) tick_1hz = 1'b0;
        @(negedge clk);
        secs = hms(5, 5, 5);
        chk48("R5 load priority", time_out, to_asc(secs));

        // R6 invalid loads ignored
        held = time_out;
        pulse_load(1'b0, 48'h323430303030); chk48("R6 hour 24", time_out, held);
        pulse_load(1'b0, 48'h313236303030); chk48("R6 minute tens 6", time_out, held);
        pulse_load(1'b0, 48'h313A30303030); chk48("R6 hour ones colon", time_out, held);
        pulse_load(1'b0, 48'h31323330302F); chk48("R6 below zero", time_out, held);
        pulse_load(1'b0, 48'h333030303030); chk48("R6 hour tens 3", time_out, held);
        pulse_load(1'b1, 48'h303036303030); chk48("R6 alarm invalid", alarm_time, 48'h303030303030);
        chk48("R6 snooze untouched", snooze_time, 48'h303030303030);

        // R7 alarm load copies to snooze
        a = hms(1, 0, 5);
        pulse_load(1'b1, to_asc(a));
        chk48("R7 alarm", alarm_time, to_asc(a));
        chk48("R7 snooze", snooze_time, to_asc(a));

        // R8 disabled: no fire on match
        set_time(a - 1);
        do_tick();
        chk1("R8 no fire when disabled", alarm_active, 1'b0);

        // R10 toggle
        pulse_toggle();
        chk1("R10 toggle on", alarm_en, 1'b1);

        // R8 load into match does not fire
        set_time(a);
        @(negedge clk);
        chk1("R8 no fire on load", alarm_active, 1'b0);
        chk1("R11 silent", tone, 1'b0);

        // R8 fire on step
        set_time(a - 2);
        do_tick();
        chk1("R8 before match", alarm_active, 1'b0);
        do_tick();
        chk1("R8 fire", alarm_active, 1'b1);

        // R11 tone: 20 high samples in 40 cycles
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tone) hi++;
        end
        checks++;
        if (hi != 20) begin
            errors++;
            $display("FAIL R11 tone high count actual=%0d expected=20", hi);
        end

        do_tick();
        chk1("R8 latched", alarm_active, 1'b1);

        // R9 snooze
        pulse_snooze();
        chk1("R9 off", alarm_active, 1'b0);
        chk48("R9 target", snooze_time, to_asc(a + 180));
        chk48("R9 alarm kept", alarm_time, to_asc(a));
        pulse_snooze();
        chk48("R9 idle ignored", snooze_time, to_asc(a + 180));
        set_time(a + 179);
        do_tick();
        chk1("R9 refire", alarm_active, 1'b1);

        // R10 dismiss
        pulse_dismiss();
        chk1("R10 dismiss active", alarm_active, 1'b0);
        chk1("R10 dismiss en", alarm_en, 1'b0);
        chk1("R11 quiet after dismiss", tone, 1'b0);

        // R10 dismiss beats toggle
        @(negedge clk);
        dismiss_req = 1'b1;
        toggle_en = 1'b1;
        @(negedge clk);
        dismiss_req = 1'b0;
        toggle_en = 1'b0;
        chk1("R10 dismiss wins", alarm_en, 1'b0);

        // R9 snooze wraps past midnight
        a = hms(23, 58, 30);
        pulse_load(1'b1, to_asc(a));
        pulse_toggle();
        set_time(a - 1);
        do_tick();
        chk1("R8 fire late", alarm_active, 1'b1);
        pulse_snooze();
        chk48("R9 wrap", snooze_time, to_asc((a + 180) % 86400));
        pulse_toggle();
        chk1("R10 toggle off", alarm_en, 1'b0);

        done = 1;
        finish_run();
    end

endmodule